// File: doc/BRIEF.md
# Clock Buffer Power-Up and Lock Sequencer

This block takes a differential clock buffer from power-off to normal output operation. It runs on a free-running system clock and steps through four phases. First it stays off until the supply detector reports a valid supply. It then runs a fixed startup delay, set by a parameter in system clock cycles; at 200 MHz a delay of 0.2 to 0.3 ms is 40,000 to 60,000 cycles. Next it waits for power-down to be released. Finally it enables the outputs. When the buffer runs in PLL mode, the waiting phase also needs a detected input clock and a locked PLL, so the outputs stay disabled until a reference clock is present.

On the same edge that enables the outputs, the block raises a latched lock indication. After that, the lock indication ignores the PLL status and the clock-presence detector. It clears only when power-down is asserted or the supply drops. The power-down input comes in already corrected for polarity, so high always means "power down". The clock-presence and PLL-lock inputs come from other clock domains and pass through a synchronizer chain before the block uses them.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `outputsEnable` and `lockFlag` are both 0.
- R2: The first rising edge that sees `supplyOk` high starts the startup delay. The delay then lasts `DELAY_CYCLES` edges. Outputs cannot become enabled earlier than `DELAY_CYCLES`+2 edges after `supplyOk` rises.
- R3: In bypass mode (`pllMode`=0) with `pwrDown` low, the outputs become enabled on the first edge after the delay ends. `pllLocked` and `inClkValid` are not consulted.
- R4: In PLL mode (`pllMode`=1), leaving the waiting phase needs the synchronized `inClkValid` and the synchronized `pllLocked` both high. The synchronizer has `SYNC_STAGES` (2) registers, so the outputs enable on the third edge after the later of the two inputs rises. Either input alone never enables the outputs.
- R5: While `pwrDown` is high, the outputs stay disabled in every phase. When `pwrDown` is released after the delay has finished, the outputs are re-enabled without a new startup delay.
- R6: `lockFlag` rises on the same edge as `outputsEnable`. It then stays high while `supplyOk` is high and `pwrDown` is low, whatever the values of `pllLocked` and `inClkValid`.
- R7: If `pwrDown` goes high while the outputs are enabled, both `outputsEnable` and `lockFlag` are 0 after the next edge, and the block returns to waiting.
- R8: If `supplyOk` goes low in any phase, both outputs are 0 after the next edge and the block returns to off. When the supply returns, the whole startup delay runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply detector reports a valid supply |
| pwrDown | input | 1 | Power-down request, already polarity corrected (1 = power down) |
| pllMode | input | 1 | 1 = PLL mode, 0 = bypass (fan-out) mode |
| inClkValid | input | 1 | Input reference clock detected (asynchronous) |
| pllLocked | input | 1 | PLL reports lock (asynchronous) |
| outputsEnable | output | 1 | Differential outputs enabled |
| lockFlag | output | 1 | Latched lock indication |

## Verification
On every cycle the assertions check several properties. The lock indication always equals the output enable. Lock holds while supply and power-down allow it. A supply loss or a power-down request clears the outputs one edge later. Each enable in PLL mode follows a cycle with synchronized readiness. The delay counter stays in range. Other behaviours only show up in the bench's scenarios, which compare the outputs with a behavioural model at every edge. These are the exact count of the startup delay, the two-stage synchronizer latency, the restart of the delay after a supply glitch, and re-enabling without a delay after power-down is released.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DELAY = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
    logic lockSet;
    logic lockClear;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inClkValid,
  input  logic       pllLocked,
  input  seqStrobe_t strobe,
  output logic       delayDone,
  output logic       clkReady,
  output logic       lockFlag
);

  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [1:0]       syncBits;
  logic [CNT_W-1:0] delayCnt;

  pwrseq_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (2)
  ) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({inClkValid, pllLocked}),
    .syncOut(syncBits)
  );

  assign clkReady = syncBits[1] & syncBits[0];

  // Startup delay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strobe.cntClear) begin
      delayCnt <= '0;
    end else if (strobe.cntRun && (delayCnt != CNT_LAST)) begin
      delayCnt <= delayCnt + 1'b1;
    end
  end

  assign delayDone = strobe.cntRun && (delayCnt == CNT_LAST);

  // Sticky lock indication; clear wins over set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockFlag <= 1'b0;
    end else if (strobe.lockClear) begin
      lockFlag <= 1'b0;
    end else if (strobe.lockSet) begin
      lockFlag <= 1'b1;
    end
  end

  AST_DELAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    delayCnt <= CNT_LAST); // R2

  AST_CLEAR_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (delayCnt == '0)); // R8

endmodule

// File: rtl/pwrseq_control.sv
module pwrseq_control
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       pwrDown,
  input  logic       pllMode,
  input  logic       delayDone,
  input  logic       clkReady,
  output seqStrobe_t strobe,
  output logic       outputsEnable
);

  seqState_t state, nextState;
  logic      releaseOk;

  assign releaseOk = !pwrDown && (!pllMode || clkReady);

  always_comb begin
    nextState = state;
    if (!supplyOk) begin
      nextState = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   nextState = ST_DELAY;
        ST_DELAY: if (delayDone) nextState = ST_WAIT;
        ST_WAIT:  if (releaseOk) nextState = ST_RUN;
        ST_RUN:   if (pwrDown)   nextState = ST_WAIT;
        default:  nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobe.cntClear  = (state == ST_OFF);
    strobe.cntRun    = (state == ST_DELAY);
    strobe.lockSet   = (state == ST_WAIT) && (nextState == ST_RUN);
    strobe.lockClear = pwrDown || !supplyOk;
  end

  assign outputsEnable = (state == ST_RUN);

  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (state == ST_OFF)); // R8

  AST_PWRDOWN_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> !outputsEnable); // R7

  AST_ENABLE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outputsEnable) |-> $past(!pllMode || clkReady)); // R4

  AST_WAIT_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) && ($past(state) == ST_DELAY) |-> $past(delayDone)); // R2

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 50000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic pwrDown,
  input  logic pllMode,
  input  logic inClkValid,
  input  logic pllLocked,
  output logic outputsEnable,
  output logic lockFlag
);

  seqStrobe_t strobe;
  logic       delayDone;
  logic       clkReady;

  pwrseq_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .supplyOk     (supplyOk),
    .pwrDown      (pwrDown),
    .pllMode      (pllMode),
    .delayDone    (delayDone),
    .clkReady     (clkReady),
    .strobe       (strobe),
    .outputsEnable(outputsEnable)
  );

  pwrseq_datapath #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .inClkValid(inClkValid),
    .pllLocked (pllLocked),
    .strobe    (strobe),
    .delayDone (delayDone),
    .clkReady  (clkReady),
    .lockFlag  (lockFlag)
  );

  AST_LOCK_MATCHES_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag == outputsEnable); // R6

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag && !pwrDown && supplyOk |=> lockFlag); // R6

endmodule

// File: tb/test_pwrseq_top.sv
`timescale 1ns/1ps
module test_pwrseq_top;

  localparam int D = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic pwrDown = 1'b1;
  logic pllMode = 1'b0;
  logic inClkValid = 1'b0;
  logic pllLocked = 1'b0;
  logic outputsEnable;
  logic lockFlag;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  pwrseq_top #(.DELAY_CYCLES(D), .SYNC_STAGES(2)) i_pwrseq_top (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .pwrDown(pwrDown),
    .pllMode(pllMode), .inClkValid(inClkValid), .pllLocked(pllLocked),
    .outputsEnable(outputsEnable), .lockFlag(lockFlag)
  );

  // Behavioural reference: phase number, elapsed delay, delayed input histories
  int phase = 0;
  int elapsed = 0;
  bit refLock = 0;
  bit clkHist[$];
  bit lkHist[$];

  always @(posedge clk) begin
    bit seenClk, seenLk, ready;
    if (!rstN) begin
      phase = 0; elapsed = 0; refLock = 0;
      clkHist = '{0, 0}; lkHist = '{0, 0};
    end else begin
      seenClk = clkHist[0];
      seenLk  = lkHist[0];
      ready = !pllMode || (seenClk && seenLk);
      if (pwrDown || !supplyOk) refLock = 0;
      else if (phase == 2 && ready) refLock = 1;
      if (!supplyOk) phase = 0;
      else if (phase == 0) begin phase = 1; elapsed = 0; end
      else if (phase == 1) begin
        elapsed++;
        if (elapsed == D) phase = 2;
      end
      else if (phase == 2) begin if (!pwrDown && ready) phase = 3; end
      else if (pwrDown) phase = 2;
      void'(clkHist.pop_front()); clkHist.push_back(inClkValid);
      void'(lkHist.pop_front());  lkHist.push_back(pllLocked);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      check(outputsEnable === (phase == 3), "R3 enable vs model", outputsEnable, phase == 3);
      check(lockFlag === refLock, "R6 lock vs model", lockFlag, refLock);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input string req, input bit oe, input bit lk);
    check(outputsEnable === oe, req, outputsEnable, oe);
    check(lockFlag === lk, req, lockFlag, lk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    step(3);
    expectOut("R1 reset state", 0, 0);
    rstN = 1'b1;
    step(1);
    expectOut("R1 after reset", 0, 0);

    // Bypass start-up with exact delay count
    pwrDown = 1'b0;
    supplyOk = 1'b1;
    step(D + 1);
    expectOut("R2 still in delay", 0, 0);
    step(1);
    expectOut("R3 bypass enable", 1, 1);

    // Power-down in run, hold, release
    pwrDown = 1'b1;
    step(1);
    expectOut("R7 powerdown clears", 0, 0);
    step(5);
    expectOut("R5 held powerdown", 0, 0);
    pwrDown = 1'b0;
    step(1);
    expectOut("R5 release no delay", 1, 1);

    // Supply loss, then PLL mode start-up
    supplyOk = 1'b0;
    step(1);
    expectOut("R8 supply loss", 0, 0);
    pllMode = 1'b1;
    supplyOk = 1'b1;
    step(D + 10);
    expectOut("R4 no clock no lock", 0, 0);
    inClkValid = 1'b1;
    step(6);
    expectOut("R4 clock only", 0, 0);
    inClkValid = 1'b0;
    pllLocked = 1'b1;
    step(6);
    expectOut("R4 lock only", 0, 0);
    inClkValid = 1'b1;
    step(2);
    expectOut("R4 sync latency", 0, 0);
    step(1);
    expectOut("R4 pll enable", 1, 1);

    // Sticky lock
    pllLocked = 1'b0;
    inClkValid = 1'b0;
    step(6);
    expectOut("R6 sticky lock", 1, 1);

    // Supply glitch during the delay restarts it
    supplyOk = 1'b0;
    step(1);
    supplyOk = 1'b1;
    step(3);
    supplyOk = 1'b0;
    step(1);
    expectOut("R8 glitch in delay", 0, 0);
    pllMode = 1'b0;
    supplyOk = 1'b1;
    step(D + 1);
    expectOut("R8 delay restarted", 0, 0);
    step(1);
    expectOut("R8 enable after restart", 1, 1);

    // Power-down held through start-up
    supplyOk = 1'b0;
    pwrDown = 1'b1;
    step(1);
    supplyOk = 1'b1;
    step(D + 10);
    expectOut("R5 powerdown through startup", 0, 0);
    pwrDown = 1'b0;
    step(1);
    expectOut("R5 release after startup", 1, 1);

    step(2);
    finishRun();
  end

endmodule